// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

The block moves data between an 18-bit narrow port and a 36-bit wide port, all on one clock. The wide port has two 18-bit halves: the low half (bits 17:0, called the first half) and the high half (bits 35:18, called the second half). In the narrow-to-wide direction, two narrow words that arrive in turn are packed into one wide word, and both halves change on the same edge. In the wide-to-narrow direction, a wide word is captured and then put out on the narrow port one half at a time. A select input sets the phase of both paths on every edge.

The direction input passes through a register, so a turnaround takes effect only at a clock edge. An active-low output enable acts at once. Each port's three-state driver is modelled as a data bus plus a drive flag. The data registers keep running whatever the direction and the enable are; direction and enable only decide which port is driven.

Top module: `bus_exchanger`

## Requirements
- R1: While rst_ni is low, every register is cleared: a_o and b_o are 0, and the registered direction is wide-to-narrow (0). With oe_ni low, a_oe_o is then 1 and b_oe_o is 0.
- R2: A rising edge with sel_i=0 loads a_i into the staging register and leaves b_o unchanged.
- R3: A rising edge with sel_i=1 sets b_o[35:18] to a_i and b_o[17:0] to the word staged earlier, so both halves update together.
- R4: A narrow word taken with sel_i=0 reaches b_o[17:0] on the second rising edge counted from its capture, paired with the word taken on that second edge.
- R5: A rising edge with sel_i=0 captures all of b_i into the wide holding register and sets a_o to the high half (bits 35:18) of the word held before that edge.
- R6: A rising edge with sel_i=1 sets a_o to the low half (bits 17:0) of the held wide word and leaves the held word unchanged.
- R7: While oe_ni is 1, a_oe_o and b_oe_o are both 0, with no clock edge needed.
- R8: dir_i is sampled on the rising edge. A change of dir_i between edges leaves the drive flags unchanged until the next rising edge.
- R9: While oe_ni is 0, exactly one drive flag is 1. b_oe_o is 1 when the registered direction is 1 (narrow-to-wide), and a_oe_o is 1 when it is 0.
- R10: Both data paths capture on every edge, whatever the direction and the enable are. b_o and a_o carry the current register contents even when their drive flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Phase select for both paths |
| dir_i | input | 1 | Direction: 1 narrow-to-wide, 0 wide-to-narrow; registered |
| oe_ni | input | 1 | Output enable, active low |
| a_i | input | 18 | Narrow port input data |
| b_i | input | 36 | Wide port input data; [17:0] first half, [35:18] second half |
| a_o | output | 18 | Narrow port output data |
| a_oe_o | output | 1 | Narrow port drive flag |
| b_o | output | 36 | Wide port output data |
| b_oe_o | output | 1 | Wide port drive flag |

## Verification
The assertions check on every cycle that:
- the drive flags are never both on and both go off while the enable is off;
- each flag follows the direction sampled at the previous edge;
- a select-low edge leaves the wide output stable;
- a select-high edge leaves the held wide word stable;
- the newest narrow word and the high half of the held word land in the right places one edge later.

The two-edge latency, the pairing of successive words, the check that a mid-cycle direction change does nothing before the edge, and the independence of the data paths from direction and enable are shown only by the bench's scenarios. The bench checks these against its own reference model.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int unsigned NARROW_W = 18;
  localparam int unsigned WIDE_W   = 2 * NARROW_W;
  typedef enum logic {DIR_TO_NARROW = 1'b0, DIR_TO_WIDE = 1'b1} dir_e;
endpackage

// File: rtl/bx_gather.sv
module bx_gather #(
  parameter int unsigned NW = bx_pkg::NARROW_W,
  localparam int unsigned WW = 2 * NW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic [NW-1:0] a_i,
  output logic [WW-1:0] b_o
);
  logic [NW-1:0] stage_q;
  logic [NW-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (!sel_i) begin
      stage_q <= a_i;
    end else begin
      lo_q <= stage_q;
      hi_q <= a_i;
    end
  end

  assign b_o = {hi_q, lo_q};

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(b_o));
  assert_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |=> b_o[WW-1:NW] == $past(a_i));
endmodule

// File: rtl/bx_split.sv
module bx_split #(
  parameter int unsigned NW = bx_pkg::NARROW_W,
  localparam int unsigned WW = 2 * NW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic [WW-1:0] b_i,
  output logic [NW-1:0] a_o
);
  logic [WW-1:0] hold_q;
  logic [NW-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
    end else if (!sel_i) begin
      hold_q <= b_i;
      out_q  <= hold_q[WW-1:NW];
    end else begin
      out_q  <= hold_q[NW-1:0];
    end
  end

  assign a_o = out_q;

  assert_hi_half_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> a_o == $past(hold_q[WW-1:NW]));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |=> $stable(hold_q));
endmodule

// File: rtl/bx_dir_ctl.sv
module bx_dir_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_i,
  input  logic oe_ni,
  output logic a_oe_o,
  output logic b_oe_o
);
  import bx_pkg::*;
  dir_e dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= DIR_TO_NARROW;
    else         dir_q <= dir_e'(dir_i);
  end

  assign a_oe_o = !oe_ni && (dir_q == DIR_TO_NARROW);
  assign b_oe_o = !oe_ni && (dir_q == DIR_TO_WIDE);

  always_comb begin
    if (oe_ni) assert_off_R7: assert (!a_oe_o && !b_oe_o);
  end

  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> $onehot({a_oe_o, b_oe_o}));
  assert_turn_wide_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_i |=> (oe_ni || b_oe_o));
  assert_turn_narrow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_i |=> (oe_ni || a_oe_o));
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
  parameter int unsigned NW = bx_pkg::NARROW_W,
  localparam int unsigned WW = 2 * NW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          dir_i,
  input  logic          oe_ni,
  input  logic [NW-1:0] a_i,
  input  logic [WW-1:0] b_i,
  output logic [NW-1:0] a_o,
  output logic          a_oe_o,
  output logic [WW-1:0] b_o,
  output logic          b_oe_o
);
  bx_gather #(.NW(NW)) i_gather (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .a_i(a_i), .b_o(b_o)
  );

  bx_split #(.NW(NW)) i_split (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .b_i(b_i), .a_o(a_o)
  );

  bx_dir_ctl i_dir_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_i(dir_i), .oe_ni(oe_ni),
    .a_oe_o(a_oe_o), .b_oe_o(b_oe_o)
  );
endmodule

// File: tb/test_bus_exchanger.sv
module test_bus_exchanger;
  localparam int NW = 18;
  localparam int WW = 36;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sel_i = 1'b0, dir_i = 1'b0, oe_ni = 1'b0;
  logic [NW-1:0] a_i = '0;
  logic [WW-1:0] b_i = '0;
  logic [NW-1:0] a_o;
  logic [WW-1:0] b_o;
  logic          a_oe_o, b_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [NW-1:0] m_stage = '0, m_a = '0;
  logic [WW-1:0] m_b = '0, m_hold = '0;
  logic          m_dir = 1'b0;

  always #2 clk = ~clk;

  bus_exchanger i_bus_exchanger (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .dir_i(dir_i), .oe_ni(oe_ni),
    .a_i(a_i), .b_i(b_i), .a_o(a_o), .a_oe_o(a_oe_o), .b_o(b_o), .b_oe_o(b_oe_o)
  );

  function automatic logic exp_a_oe(logic oe_n, logic d);
    return !oe_n && !d;
  endfunction
  function automatic logic exp_b_oe(logic oe_n, logic d);
    return !oe_n && d;
  endfunction

  task automatic chk(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(logic s);
    chk(s ? "R3" : "R2", b_o, m_b);
    chk(s ? "R6" : "R5", {18'd0, a_o}, {18'd0, m_a});
    chk(oe_ni ? "R7" : "R9", {35'd0, a_oe_o}, {35'd0, exp_a_oe(oe_ni, m_dir)});
    chk(oe_ni ? "R7" : "R9", {35'd0, b_oe_o}, {35'd0, exp_b_oe(oe_ni, m_dir)});
  endtask

  // one clock: drive on falling edge, update model at rising edge, sample 1 ns later
  task automatic step(logic s, logic d, logic oe, logic [NW-1:0] a, logic [WW-1:0] b);
    @(negedge clk);
    sel_i = s; dir_i = d; oe_ni = oe; a_i = a; b_i = b;
    @(posedge clk);
    if (s) begin
      m_b = {a, m_stage};
      m_a = m_hold[NW-1:0];
    end else begin
      m_stage = a;
      m_a = m_hold[WW-1:NW];
      m_hold = b;
    end
    m_dir = d;
    #1;
    chk_all(s);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NW-1:0] w0, w1;
    logic [WW-1:0] wb;
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", b_o, '0);
    chk("R1", {18'd0, a_o}, '0);
    chk("R1", {35'd0, a_oe_o}, 36'd1);
    chk("R1", {35'd0, b_oe_o}, 36'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R4: two-edge latency and pairing
    w0 = 18'h2A5A5; w1 = 18'h15A5A;
    step(1'b0, 1'b1, 1'b0, w0, '0);
    chk("R4", b_o, '0);
    step(1'b1, 1'b1, 1'b0, w1, '0);
    chk("R4", b_o, {w1, w0});

    // R5/R6: wide word split into halves
    wb = 36'hA_BCDE_1234;
    step(1'b0, 1'b0, 1'b0, '0, wb);
    step(1'b1, 1'b0, 1'b0, '0, '0);
    chk("R6", {18'd0, a_o}, {18'd0, wb[NW-1:0]});
    step(1'b0, 1'b0, 1'b0, '0, '0);
    chk("R5", {18'd0, a_o}, {18'd0, wb[WW-1:NW]});

    // R8: mid-cycle direction change has no effect before the edge
    @(negedge clk);
    dir_i = 1'b1; sel_i = 1'b1;
    #1;
    chk("R8", {35'd0, a_oe_o}, 36'd1);
    chk("R8", {35'd0, b_oe_o}, 36'd0);
    @(posedge clk);
    m_b = {a_i, m_stage}; m_a = m_hold[NW-1:0]; m_dir = 1'b1;
    #1;
    chk("R8", {35'd0, b_oe_o}, 36'd1);
    chk("R8", {35'd0, a_oe_o}, 36'd0);

    // R7: enable off acts without a clock edge
    @(negedge clk);
    oe_ni = 1'b1;
    #1;
    chk("R7", {34'd0, a_oe_o, b_oe_o}, 36'd0);

    // R10: paths capture while disabled and direction is the other way
    w0 = 18'h0BEEF; w1 = 18'h3C0DE;
    step(1'b0, 1'b0, 1'b1, w0, '0);
    step(1'b1, 1'b0, 1'b1, w1, '0);
    chk("R10", b_o, {w1, w0});
    wb = 36'h5_0F0F_F0F0;
    step(1'b0, 1'b1, 1'b1, '0, wb);
    step(1'b1, 1'b1, 1'b1, '0, '0);
    chk("R10", {18'd0, a_o}, {18'd0, wb[NW-1:0]});

    // random phase with alternating and irregular select
    for (int i = 0; i < 400; i++) begin
      logic s, d, oe;
      s  = (i < 200) ? logic'(i % 2) : logic'($urandom_range(0, 1));
      d  = ($urandom_range(0, 7) == 0) ? ~dir_i : dir_i;
      oe = ($urandom_range(0, 5) == 0);
      step(s, d, oe, NW'($urandom), {4'($urandom), 32'($urandom)});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule